// File: doc/BRIEF.md
# Congestion-Weighted Aging Priority Arbiter

This block chooses which of several router input ports may use one output port of a mesh network router. A port asks for the output by presenting the head flit of a packet. The head flit carries a 4-bit priority value. That value is larger when the packet has crossed more congested parts of the network on its way here. When several ports ask at once, the port with the largest effective priority wins. Every port that asks and loses is aged: its effective priority rises by one, up to a ceiling, so a packet from a quiet region still gets through in the end.

Once a port wins, it owns the output for the whole packet. The grant stays on until that port's tail flit is transferred. A transfer is any cycle in which the port's flit is valid while its grant is high. The block has two control states. In IDLE no port owns the output. The ARBITRATE transition goes from IDLE to LOCKED when at least one head flit is waiting, and it also records the winner. IDLE stays in IDLE when no head flit is waiting. LOCKED stays in LOCKED while the owner's tail flit has not yet been transferred. The RELEASE transition goes from LOCKED back to IDLE in the cycle the owner's tail flit is transferred. The grant appears one cycle after the decision and drops one cycle after the tail.

A requesting port must keep its head flit valid until it is granted. The block has no datapath, no buffering and no route computation.

Top module: `cwa_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `grant` is all zeros and `grant_valid` is low.
- R2: In IDLE, if no port presents a head flit (`flit_valid[i] & flit_head[i]`), the next cycle shows `grant_valid` low and `grant` all zeros.
- R3: In IDLE, when at least one head flit is present, the port with the largest effective priority is granted in the following cycle. A port's effective priority is its aged counter if it has lost an earlier decision with the same packet, and otherwise the `hdr_prio` value it presents.
- R4: If two or more requesting ports share the largest effective priority, the one with the lowest port index wins.
- R5: At each decision, every requesting port that loses gets its effective priority raised by one. The value stops at 15 and never wraps.
- R6: `grant` has at most one bit set, and `grant_valid` is high exactly when a bit of `grant` is set.
- R7: The grant stays unchanged until the owner's tail flit is transferred. A tail flit is transferred when `flit_valid` and `flit_tail` are both high for the granted port. In the cycle after that transfer, `grant_valid` is low.
- R8: A granted port's aged value is discarded. Its next packet competes with the header priority that packet carries.
- R9: From IDLE with a head flit present, `grant_valid` is high in the next cycle. A decision is made only in IDLE, so the aged values of waiting ports do not change while a packet is being transferred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flit_valid | input | N_PORTS | A flit is present at input port i |
| flit_head | input | N_PORTS | The flit at port i is a head flit |
| flit_tail | input | N_PORTS | The flit at port i is a tail flit |
| hdr_prio | input | N_PORTS*PRIO_W | Header priority of port i, held in bits [i*PRIO_W +: PRIO_W] |
| grant | output | N_PORTS | One-hot grant of the output port |
| grant_valid | output | 1 | The output port is owned by a granted input |

## Verification
The assertions check these properties on every cycle: the one-hot form of the grant and its agreement with `grant_valid`, the one-cycle decision latency, that a grant stays stable until the tail, the release after the tail, and the idle output when nothing is requested. Choosing the correct winner depends on the aging history across many decisions. That covers tie order, saturation at 15 and the reload of the header value after a win. Only the bench's scenarios can show these, by comparing each grant against a reference model of effective priorities. The model is driven by random traffic and by directed sequences that reach the ceiling and then create ties at it.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

    // Control states of the output-port owner
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOCKED = 1'b1
    } cwa_state_e;

    localparam int unsigned CWA_DEF_PORTS  = 5;
    localparam int unsigned CWA_DEF_PRIO_W = 4;

endpackage

// File: rtl/cwa_age_counter.sv
// Per-port effective priority: header bypass for a fresh request,
// saturating aged value once the port has lost a decision.
module cwa_age_counter #(
    parameter int unsigned PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              decide_i,
    input  logic              req_i,
    input  logic              won_i,
    input  logic [PRIO_W-1:0] hdr_prio_i,
    output logic [PRIO_W-1:0] eff_o
);
    localparam logic [PRIO_W-1:0] PRIO_MAX = {PRIO_W{1'b1}};

    logic              aged_q;
    logic [PRIO_W-1:0] cnt_q;
    logic [PRIO_W-1:0] bumped;

    always_comb begin
        eff_o  = aged_q ? cnt_q : hdr_prio_i;
        bumped = (eff_o == PRIO_MAX) ? PRIO_MAX : eff_o + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aged_q <= 1'b0;
            cnt_q  <= '0;
        end else if (decide_i) begin
            if (won_i) begin
                aged_q <= 1'b0;
            end else if (req_i) begin
                aged_q <= 1'b1;
                cnt_q  <= bumped;
            end
        end
    end
endmodule

// File: rtl/cwa_max_select.sv
// Picks the requesting port with the largest value; the scan keeps the
// first maximum found, so ties go to the lowest index.
module cwa_max_select #(
    parameter int unsigned N_PORTS = 5,
    parameter int unsigned PRIO_W  = 4,
    localparam int unsigned IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic [N_PORTS-1:0]        req_i,
    input  logic [N_PORTS*PRIO_W-1:0] eff_i,
    output logic                      any_o,
    output logic [IDX_W-1:0]          win_o
);
    logic [PRIO_W-1:0] best_val;

    always_comb begin
        any_o    = 1'b0;
        win_o    = '0;
        best_val = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (req_i[i] && (!any_o || (eff_i[i*PRIO_W +: PRIO_W] > best_val))) begin
                any_o    = 1'b1;
                win_o    = IDX_W'(i);
                best_val = eff_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/cwa_grant_fsm.sv
// Ownership state machine: IDLE -> LOCKED on a decision, back on the tail.
module cwa_grant_fsm
    import cwa_pkg::*;
#(
    parameter int unsigned N_PORTS = 5,
    localparam int unsigned IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_req_i,
    input  logic [IDX_W-1:0]   win_i,
    input  logic [N_PORTS-1:0] flit_valid_i,
    input  logic [N_PORTS-1:0] flit_tail_i,
    output logic               decide_o,
    output logic [N_PORTS-1:0] grant_o,
    output logic               grant_valid_o
);
    cwa_state_e       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d;
    logic             tail_done;

    assign tail_done = flit_valid_i[owner_q] & flit_tail_i[owner_q];

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req_i) begin
                    state_d = ST_LOCKED;
                    owner_d = win_i;
                end
            end
            ST_LOCKED: begin
                if (tail_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        grant_o       = '0;
        grant_valid_o = 1'b0;
        decide_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                decide_o = any_req_i;
            end
            ST_LOCKED: begin
                grant_o[owner_q] = 1'b1;
                grant_valid_o    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cwa_arbiter.sv
module cwa_arbiter #(
    parameter int unsigned N_PORTS = cwa_pkg::CWA_DEF_PORTS,
    parameter int unsigned PRIO_W  = cwa_pkg::CWA_DEF_PRIO_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PORTS-1:0]        flit_valid,
    input  logic [N_PORTS-1:0]        flit_head,
    input  logic [N_PORTS-1:0]        flit_tail,
    input  logic [N_PORTS*PRIO_W-1:0] hdr_prio,
    output logic [N_PORTS-1:0]        grant,
    output logic                      grant_valid
);
    localparam int unsigned IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    logic [N_PORTS-1:0]        head_req;
    logic [N_PORTS*PRIO_W-1:0] eff_all;
    logic [N_PORTS-1:0]        won_vec;
    logic                      any_req;
    logic                      decide;
    logic [IDX_W-1:0]          win_idx;

    assign head_req = flit_valid & flit_head;

    always_comb begin
        won_vec = '0;
        if (decide) begin
            won_vec[win_idx] = 1'b1;
        end
    end

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        cwa_age_counter #(.PRIO_W(PRIO_W)) u_age (
            .clk        (clk),
            .rst_n      (rst_n),
            .decide_i   (decide),
            .req_i      (head_req[g]),
            .won_i      (won_vec[g]),
            .hdr_prio_i (hdr_prio[g*PRIO_W +: PRIO_W]),
            .eff_o      (eff_all[g*PRIO_W +: PRIO_W])
        );
    end

    cwa_max_select #(.N_PORTS(N_PORTS), .PRIO_W(PRIO_W)) u_sel (
        .req_i (head_req),
        .eff_i (eff_all),
        .any_o (any_req),
        .win_o (win_idx)
    );

    cwa_grant_fsm #(.N_PORTS(N_PORTS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .any_req_i     (any_req),
        .win_i         (win_idx),
        .flit_valid_i  (flit_valid),
        .flit_tail_i   (flit_tail),
        .decide_o      (decide),
        .grant_o       (grant),
        .grant_valid_o (grant_valid)
    );
endmodule

// File: rtl/cwa_arbiter_chk.sv
module cwa_arbiter_chk #(
    parameter int unsigned N_PORTS = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PORTS-1:0] flit_valid,
    input logic [N_PORTS-1:0] flit_head,
    input logic [N_PORTS-1:0] flit_tail,
    input logic [N_PORTS-1:0] grant,
    input logic               grant_valid
);
    logic [N_PORTS-1:0] heads;
    logic               tail_xfer;

    assign heads     = flit_valid & flit_head;
    assign tail_xfer = |(grant & flit_valid & flit_tail);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!grant_valid && grant == '0));

    p_idle_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && heads == '0) |=> (!grant_valid && grant == '0));

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_valid == (grant != '0)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !tail_xfer) |=> (grant_valid && $stable(grant)));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && tail_xfer) |=> !grant_valid);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && heads != '0) |=> grant_valid);

    p_to_requester_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && heads != '0) |=> ((grant & $past(heads)) == grant));
endmodule

bind cwa_arbiter cwa_arbiter_chk #(.N_PORTS(N_PORTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flit_valid  (flit_valid),
    .flit_head   (flit_head),
    .flit_tail   (flit_tail),
    .grant       (grant),
    .grant_valid (grant_valid)
);

// File: tb/cwa_arbiter_bench.sv
`timescale 1ns/1ps
module cwa_arbiter_bench;
    localparam int NP = 5;
    localparam int PW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     flit_valid = '0;
    logic [NP-1:0]     flit_head = '0;
    logic [NP-1:0]     flit_tail = '0;
    logic [NP*PW-1:0]  hdr_prio = '0;
    logic [NP-1:0]     grant;
    logic              grant_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench-side view of the traffic and of the expected priorities
    bit       want  [NP];
    int       prio  [NP];
    bit       mpend [NP];
    int       mcnt  [NP];

    always #2 clk = ~clk;

    cwa_arbiter #(.N_PORTS(NP), .PRIO_W(PW)) u_cwa_arbiter (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
        .flit_tail(flit_tail), .hdr_prio(hdr_prio), .grant(grant), .grant_valid(grant_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_of(input int i);
        return mpend[i] ? mcnt[i] : prio[i];
    endfunction

    function automatic int pick_winner();
        int w = -1;
        for (int i = 0; i < NP; i++)
            if (want[i] && (w < 0 || eff_of(i) > eff_of(w))) w = i;
        return w;
    endfunction

    function automatic bit has_tie(input int w);
        for (int i = 0; i < NP; i++)
            if (want[i] && i != w && eff_of(i) == eff_of(w)) return 1;
        return 0;
    endfunction

    task automatic drive_requests();
        for (int i = 0; i < NP; i++) begin
            flit_valid[i] = want[i];
            flit_head[i]  = want[i];
            flit_tail[i]  = 1'b0;
            hdr_prio[i*PW +: PW] = PW'(prio[i]);
        end
    endtask

    // Entered and left at a falling edge with the block in IDLE.
    task automatic do_round(input int len);
        int w;
        bit tie;
        drive_requests();
        w   = pick_winner();
        tie = (w >= 0) ? has_tie(w) : 0;
        @(negedge clk);
        if (w < 0) begin
            chk(!grant_valid && grant == '0, "R2", int'(grant_valid), 0);
            return;
        end
        chk(grant_valid, "R9", int'(grant_valid), 1);
        if (tie) chk(grant == NP'(1 << w), "R4", int'(grant), 1 << w);
        else     chk(grant == NP'(1 << w), "R3", int'(grant), 1 << w);
        for (int i = 0; i < NP; i++) begin
            if (i == w) mpend[i] = 0;
            else if (want[i]) begin
                mcnt[i]  = (eff_of(i) >= 15) ? 15 : eff_of(i) + 1;
                mpend[i] = 1;
            end
        end
        for (int k = 0; k < len; k++) begin
            drive_requests();
            flit_valid[w] = 1'b1;
            flit_head[w]  = (k == 0);
            flit_tail[w]  = (k == len - 1);
            @(negedge clk);
            if (k < len - 1)
                chk(grant_valid && grant == NP'(1 << w), "R7", int'(grant), 1 << w);
            else
                chk(!grant_valid && grant == '0, "R7", int'(grant), 0);
        end
        want[w] = 0;
    endtask

    task automatic set_req(input int i, input int p);
        want[i] = 1;
        prio[i] = p;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0A_5EED));
        for (int i = 0; i < NP; i++) begin
            want[i] = 0; prio[i] = 0; mpend[i] = 0; mcnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(!grant_valid && grant == '0, "R1", int'(grant), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!grant_valid && grant == '0, "R1", int'(grant_valid), 0);

        // R2: nothing requested
        do_round(1);

        // R3: clear maximum at port 2
        set_req(0, 3); set_req(2, 9); set_req(4, 5);
        do_round(2);
        // R4: aged port 4 (6) ties with fresh port 1 at 6? port 0 aged to 4
        set_req(1, 6);
        do_round(1);
        do_round(3);
        do_round(1);

        // R5: age port 4 up to the ceiling, then tie at 15
        set_req(0, 15); set_req(4, 14);
        do_round(1);              // port 0 wins, port 4 aged to 15
        set_req(0, 15);
        do_round(2);              // tie at 15, port 0 wins, port 4 stays 15
        set_req(3, 0);
        do_round(1);              // port 4 (15, no wrap) beats port 3
        do_round(1);

        // R8: winner's next packet uses its own new header value
        set_req(1, 2); set_req(2, 1);
        do_round(1);              // port 1 wins, port 2 aged to 2
        set_req(1, 2);
        do_round(1);              // R8: fresh 2 ties aged 2, port 1 wins on index
        do_round(1);

        // random traffic
        for (int r = 0; r < 400; r++) begin
            for (int i = 0; i < NP; i++)
                if (!want[i] && ($urandom % 3) == 0) set_req(i, int'($urandom % 16));
            do_round(1 + int'($urandom % 4));
        end
        while (pick_winner() >= 0) do_round(1);
        do_round(1);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule